// File: doc/BRIEF.md
# Ring Polarity Period Detector

This block watches the two digitised polarity comparators of a telephone line interface. One comparator reports that its lead sits below the reference. The other reports that its lead sits above it. The block turns each comparator into a status bit that is sampled on a 2048 Hz timing enable. It raises an interrupt on one chosen edge of each status bit: the falling edge of the "low" status and the rising edge of the "high" status. Each interrupt is given both as a one-cycle pulse and as a sticky flag. The flag stays set until software clears it.

The block also times the ringing cycle in ticks of 1/2048 s. The cycle is a high interrupt, then one or more low interrupts, then a closing high interrupt. The result goes to an 8-bit period register, which starts at its ceiling of 255. The register is rewritten on every high interrupt and at no other time. It takes the measured tick count only when a full sequence has been seen and the time since the previous high interrupt fits in 8 bits. In every other case it takes 255.

Top module: `ring_period_detector`

## Requirements
- R1: After reset the status bits, pulses and flags are 0 and the period register reads 255.
- R2: Each status bit copies its comparator, after a two-flop synchroniser, only on a cycle where `tick_i` is high. Between ticks the status bits hold, even if the comparators change.
- R3: `irq_low_o` pulses for one cycle right after a tick on which `stat_low_o` goes from 1 to 0. A 0-to-1 change of `stat_low_o` gives no pulse.
- R4: `irq_high_o` pulses for one cycle right after a tick on which `stat_high_o` goes from 0 to 1. A 1-to-0 change of `stat_high_o` gives no pulse.
- R5: Each flag is set in the same cycle as its pulse. It stays set until a clear pulse: `clr_i[0]` clears the low flag and `clr_i[1]` clears the high flag. When a set and a clear land on the same edge, the set wins.
- R6: `period_o` changes only in the cycle in which `irq_high_o` is high.
- R7: A high interrupt with no low interrupt since the previous high interrupt, or since reset, writes 255.
- R8: After a high interrupt and then at least one low interrupt, the next high interrupt writes the number of ticks from the earlier high interrupt to this one. The count includes this tick and excludes the earlier one.
- R9: If that count exceeds 255, the high interrupt writes 255 whatever came in between. A count of exactly 255 also reads 255.
- R10: A closing high interrupt also opens the next sequence. Back-to-back cycles each give a measurement.
- R11: A low interrupt before any high interrupt since reset does not arm a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 2048 Hz enable, one clock wide |
| cmp_low_i | input | 1 | Comparator: lead below reference |
| cmp_high_i | input | 1 | Comparator: lead above reference |
| clr_i | input | 2 | Write-one-to-clear pulses: bit 0 low flag, bit 1 high flag |
| stat_low_o | output | 1 | Low status bit |
| stat_high_o | output | 1 | High status bit |
| irq_low_o | output | 1 | One-cycle pulse on a 1-to-0 change of the low status |
| irq_high_o | output | 1 | One-cycle pulse on a 0-to-1 change of the high status |
| flag_low_o | output | 1 | Sticky low interrupt flag |
| flag_high_o | output | 1 | Sticky high interrupt flag |
| period_o | output | 8 | Ringer period register in 1/2048 s units |

## Verification
The hardest cases to reach are at the saturation boundary. There, a valid sequence must still read 255 because the gap between high interrupts has reached 255 or 256 ticks. Reaching it takes hundreds of ticks with the right edges in between. The stimulus repeats complete high-low-high cycles and adds 0 to 255 idle ticks before each closing edge, so the gaps run from 4 to 259 ticks. Every cycle also opens the next one. The expected period for each gap is worked out by arithmetic in the bench.

// File: rtl/ring_period_detector.sv
module ring_period_detector #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cmp_low_i,
  input  logic             cmp_high_i,
  input  logic [1:0]       clr_i,
  output logic             stat_low_o,
  output logic             stat_high_o,
  output logic             irq_low_o,
  output logic             irq_high_o,
  output logic             flag_low_o,
  output logic             flag_high_o,
  output logic [CNT_W-1:0] period_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {ARM_IDLE, ARM_WAIT_LOW, ARM_SAW_LOW} arm_t;

  logic [SYNC_STAGES-1:0] sync_low, sync_high;
  logic [CNT_W-1:0]       tick_cnt;
  arm_t                   arm;

  wire low_s   = sync_low[SYNC_STAGES-1];
  wire high_s  = sync_high[SYNC_STAGES-1];
  wire ev_low  = tick_i & stat_low_o & ~low_s;
  wire ev_high = tick_i & ~stat_high_o & high_s;
  wire measure = (arm == ARM_SAW_LOW) && (tick_cnt != CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_low  <= '0;
      sync_high <= '0;
    end else begin
      sync_low  <= {sync_low[SYNC_STAGES-2:0], cmp_low_i};
      sync_high <= {sync_high[SYNC_STAGES-2:0], cmp_high_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_low_o  <= 1'b0;
      stat_high_o <= 1'b0;
      irq_low_o   <= 1'b0;
      irq_high_o  <= 1'b0;
      flag_low_o  <= 1'b0;
      flag_high_o <= 1'b0;
    end else begin
      if (tick_i) begin
        stat_low_o  <= low_s;
        stat_high_o <= high_s;
      end
      irq_low_o   <= ev_low;
      irq_high_o  <= ev_high;
      flag_low_o  <= (flag_low_o & ~clr_i[0]) | ev_low;
      flag_high_o <= (flag_high_o & ~clr_i[1]) | ev_high;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      period_o <= CNT_MAX;
      arm      <= ARM_IDLE;
    end else if (tick_i) begin
      if (ev_high) begin
        period_o <= measure ? tick_cnt + 1'b1 : CNT_MAX;
        tick_cnt <= '0;
        arm      <= ev_low ? ARM_SAW_LOW : ARM_WAIT_LOW;
      end else begin
        if (tick_cnt != CNT_MAX) tick_cnt <= tick_cnt + 1'b1;
        if (ev_low && arm == ARM_WAIT_LOW) arm <= ARM_SAW_LOW;
      end
    end
  end

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick_i) |-> ($stable(stat_low_o) && $stable(stat_high_o))); // R2
  AST_LOW_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_low_o |-> (!stat_low_o && $past(stat_low_o) && $past(tick_i))); // R3
  AST_HIGH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_high_o |-> (stat_high_o && !$past(stat_high_o) && $past(tick_i))); // R4
  AST_FLAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_low_o |-> flag_low_o) and (irq_high_o |-> flag_high_o)); // R5
  AST_PERIOD_ONLY_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_high_o |-> $stable(period_o)); // R6
  AST_ARM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    arm != 2'd3); // R8

endmodule

// File: tb/ring_period_detector_test.sv
module ring_period_detector_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic cmp_low = 1'b0;
  logic cmp_high = 1'b0;
  logic [1:0] clr = 2'b00;
  logic stat_low, stat_high, irq_low, irq_high, flag_low, flag_high;
  logic [7:0] period;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  bit m_sl, m_sh, m_fl, m_fh;
  int m_cnt, m_period, m_arm;

  ring_period_detector uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cmp_low_i(cmp_low), .cmp_high_i(cmp_high),
    .clr_i(clr), .stat_low_o(stat_low), .stat_high_o(stat_high), .irq_low_o(irq_low),
    .irq_high_o(irq_high), .flag_low_o(flag_low), .flag_high_o(flag_high), .period_o(period)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, MAX_CYCLES);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string preq, input bit el, input bit eh);
    check("R2", "stat_low", stat_low, m_sl);
    check("R2", "stat_high", stat_high, m_sh);
    check("R3", "irq_low", irq_low, el);
    check("R4", "irq_high", irq_high, eh);
    check("R5", "flag_low", flag_low, m_fl);
    check("R5", "flag_high", flag_high, m_fh);
    check(preq, "period", period, m_period);
  endtask

  task automatic set_in(input bit lo, input bit hi);
    cmp_low = lo;
    cmp_high = hi;
    repeat (3) @(negedge clk);
  endtask

  // R7 R8 R9 R10 R11: arm 0 = idle, 1 = waiting for low, 2 = low seen
  task automatic do_tick(input logic [1:0] c, input string preq);
    bit el, eh;
    el = m_sl & ~cmp_low;
    eh = ~m_sh & cmp_high;
    tick = 1'b1;
    clr = c;
    @(negedge clk);
    tick = 1'b0;
    clr = 2'b00;
    if (eh) begin
      m_period = (m_arm == 2 && m_cnt + 1 <= 254) ? m_cnt + 1 : 255;
      m_cnt = 0;
      m_arm = el ? 2 : 1;
    end else begin
      if (m_cnt < 255) m_cnt++;
      if (el && m_arm == 1) m_arm = 2;
    end
    m_sl = cmp_low;
    m_sh = cmp_high;
    m_fl = (m_fl & ~c[0]) | el;
    m_fh = (m_fh & ~c[1]) | eh;
    check_all(preq, el, eh);
  endtask

  initial begin
    m_sl = 0; m_sh = 0; m_fl = 0; m_fh = 0; m_cnt = 0; m_period = 255; m_arm = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "stat_low", stat_low, 0);
    check("R1", "stat_high", stat_high, 0);
    check("R1", "irq_high", irq_high, 0);
    check("R1", "flags", {flag_low, flag_high}, 0);
    check("R1", "period", period, 255);

    // R11: low interrupt before any high interrupt
    set_in(1, 0);
    do_tick(2'b00, "R11");
    set_in(0, 0);
    do_tick(2'b00, "R11");
    // R2: comparator change without tick leaves status
    cmp_high = 1;
    repeat (6) @(negedge clk);
    check("R2", "stat_high held", stat_high, 0);
    do_tick(2'b00, "R7");   // first high interrupt, R7
    set_in(0, 0);
    do_tick(2'b00, "R6");   // high fall: no pulse, period unchanged (R4, R6)
    set_in(0, 1);
    do_tick(2'b00, "R11");  // earlier low irq did not arm: 255
    // R5: clear the flags
    clr = 2'b11;
    @(negedge clk);
    clr = 2'b00;
    m_fl = 0; m_fh = 0;
    check("R5", "flag_low cleared", flag_low, 0);
    check("R5", "flag_high cleared", flag_high, 0);

    // R8 R9 R10: sweep idle ticks, each closing edge opens the next cycle
    for (int k = 0; k <= 255; k++) begin
      set_in(1, 1);
      do_tick(2'b00, "R6");
      set_in(0, 1);
      do_tick(2'b00, "R6");
      repeat (k) do_tick(2'b00, "R6");
      set_in(0, 0);
      do_tick(2'b00, "R6");
      set_in(0, 1);
      do_tick(2'b00, (k + 4 > 254) ? "R9" : (k == 0 ? "R8" : "R10"));
    end

    // R7: two high interrupts with no low interrupt between
    set_in(0, 0);
    do_tick(2'b00, "R6");
    set_in(0, 1);
    do_tick(2'b00, "R7");

    // R5: set wins over a simultaneous clear
    set_in(0, 0);
    do_tick(2'b00, "R6");
    set_in(0, 1);
    do_tick(2'b10, "R7");
    check("R5", "set beats clear", flag_high, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule